// File: doc/BRIEF.md
# Halfword-Swapping DMA Memory Bridge

This block sits between a DMA-capable peripheral and a 32-bit memory request port. It takes one transfer request at a time (address, length, direction, mode) and turns it into one or more burst requests on the memory side. Each burst request waits for acceptance and then for completion.

Two kinds of peripheral are served. A 16-bit peripheral gives its own address, and the bridge ORs that address with a base register to form the memory address. If the request asks for swapping, the bridge forces both the address and the length to even values. It then exchanges the two bytes of every 16-bit halfword on both data paths, and it cuts writes into bursts of at most `CHUNK` bytes. A byte-stream peripheral ignores the request address. It uses a current-address register instead, and the bridge advances that register by the transfer length once the transfer has finished.

The controller has four states. `ST_IDLE` waits for a request. `ST_ISSUE` presents a burst request until `mem_ready` accepts it. `ST_WAIT` waits for `mem_ack`. `ST_FINISH` raises `done` for one cycle. The transitions are:

- accept: `ST_IDLE` to `ST_ISSUE`, or to `ST_FINISH` when the effective length is zero.
- handoff: `ST_ISSUE` to `ST_WAIT`, on `mem_ready`.
- next burst: `ST_WAIT` to `ST_ISSUE`, on `mem_ack` while bytes remain.
- last burst: `ST_WAIT` to `ST_FINISH`, on `mem_ack` when no bytes remain.
- release: `ST_FINISH` to `ST_IDLE`, unconditionally.

Top module: `hsd_dma_bridge`

## Requirements
- R1: After reset the bridge is idle: `busy`, `done` and `mem_valid` are 0, and `cur_addr` is 0.
- R2: In 16-bit mode (`req_stream`=0), the first burst address is `req_addr | base register`.
- R3: In 16-bit mode with `req_swap`=1, bit 0 of both the ORed address and the length is cleared before any burst is issued.
- R4: While a swapped 16-bit transfer is in progress, bits [15:8] and [7:0] of every 16-bit halfword are exchanged on both paths: `wr_data_in` to `mem_wdata`, and `mem_rdata` to `rd_data_out`. At all other times both paths pass data unchanged.
- R5: A swapped 16-bit write is issued as consecutive bursts of `CHUNK` (64) bytes, plus a last burst holding the remainder. Each burst starts where the previous one ended.
- R6: A swapped 16-bit read, and any unswapped 16-bit transfer, is a single burst of the full length at the formed address. An unswapped transfer has no alignment forcing.
- R7: In stream mode (`req_stream`=1), one burst of the raw length is issued at `cur_addr`, ignoring `req_addr`, `req_swap` and the base register. `cur_addr` has grown by the length when `done` is high.
- R8: A request is accepted only when `busy` is 0, and `busy` rises the cycle after acceptance. `req_valid` while busy has no effect.
- R9: `done` is high for exactly one cycle, the cycle after the edge where the last burst's `mem_ack` is taken. `busy` is 0 the cycle after that.
- R10: A request whose effective length is zero, including one made zero by even forcing, never raises `mem_valid`. `done` is high the cycle after acceptance.
- R11: A burst request holds `mem_addr`, `mem_len` and `mem_write` stable until `mem_ready`. `mem_valid` is low while waiting for `mem_ack`.
- R12: `base_load` and `cur_load` write `base_data` and `cur_data` into the base and current-address registers. A load of the current-address register is visible on `cur_addr` the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_load | input | 1 | Write strobe for the base register |
| base_data | input | AW | Base register value |
| cur_load | input | 1 | Write strobe for the current-address register |
| cur_data | input | AW | Current-address register value |
| cur_addr | output | AW | Current-address register |
| req_valid | input | 1 | Transfer request strobe |
| req_addr | input | AW | Peripheral address (16-bit mode) |
| req_len | input | LW | Transfer length in bytes |
| req_write | input | 1 | 1: write to memory, 0: read from memory |
| req_swap | input | 1 | Halfword swap mode (16-bit mode only) |
| req_stream | input | 1 | 1: byte-stream mode, 0: 16-bit mode |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Burst request valid |
| mem_ready | input | 1 | Burst request accepted |
| mem_addr | output | AW | Burst start address |
| mem_len | output | LW | Burst length in bytes |
| mem_write | output | 1 | Burst direction |
| mem_ack | input | 1 | Burst complete |
| wr_data_in | input | DW | Write data from the peripheral |
| mem_wdata | output | DW | Write data to memory |
| mem_rdata | input | DW | Read data from memory |
| rd_data_out | output | DW | Read data to the peripheral |

## Verification
The first burst request is due one cycle after the accepting edge. Each following request is due one cycle after the `mem_ack` edge of the burst before it, and `done` follows the last `mem_ack` edge by one cycle (R9), or the accepting edge by one cycle for empty requests (R10). The data paths are combinational from a state flag set at acceptance, so swap checks are made during the request cycle. The bench drives inputs on the falling edge and samples on the falling edge, so every check lands on the cycle computed from those register counts. It also steps its own memory responder one falling edge at a time: request, acceptance and completion each get their own cycle.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } hsd_state_e;
endpackage

// File: rtl/hsd_lane_swap.sv
module hsd_lane_swap #(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NH = DW / 16;

    for (genvar h = 0; h < NH; h++) begin : g_half
        assign dout[16*h +: 16] = en ? {din[16*h +: 8], din[16*h+8 +: 8]}
                                     : din[16*h +: 16];
    end
endmodule

// File: rtl/hsd_burst_sizer.sv
module hsd_burst_sizer #(
    parameter int LW    = 16,
    parameter int CHUNK = 64
) (
    input  logic [LW-1:0] rem,
    input  logic          chunked,
    output logic [LW-1:0] blen
);
    localparam logic [LW-1:0] CAP = LW'(CHUNK);

    always_comb begin
        blen = (chunked && (rem > CAP)) ? CAP : rem;
    end
endmodule

// File: rtl/hsd_addr_former.sv
module hsd_addr_former #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [AW-1:0] base_q,
    input  logic [AW-1:0] cur_q,
    input  logic          swap,
    input  logic          stream,
    output logic [AW-1:0] start_addr,
    output logic [LW-1:0] start_len,
    output logic          eff_swap
);
    logic [AW-1:0] raw_addr;

    always_comb begin
        eff_swap   = swap && !stream;
        raw_addr   = stream ? cur_q : (req_addr | base_q);
        start_addr = eff_swap ? {raw_addr[AW-1:1], 1'b0} : raw_addr;
        start_len  = eff_swap ? {req_len[LW-1:1], 1'b0} : req_len;
    end
endmodule

// File: rtl/hsd_seq.sv
module hsd_seq
    import hsd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int CHUNK = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] start_len,
    input  logic          req_write,
    input  logic          eff_swap,
    input  logic          req_stream,
    input  logic          mem_ready,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    output logic          mem_write,
    output logic          swap_act,
    output logic          adv_valid,
    output logic [LW-1:0] adv_len
);
    hsd_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic          write_q, swap_q, stream_q;
    logic [LW-1:0] blen;
    logic          accept, last_ack;

    hsd_burst_sizer #(.LW(LW), .CHUNK(CHUNK)) u_sizer (
        .rem     (rem_q),
        .chunked (swap_q && write_q),
        .blen    (blen)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign last_ack = (state_q == ST_WAIT) && mem_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = (start_len == '0) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  if (mem_ready) state_d = ST_WAIT;
            ST_WAIT:   if (mem_ack)   state_d = (rem_q == blen) ? ST_FINISH : ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rem_q    <= '0;
            write_q  <= 1'b0;
            swap_q   <= 1'b0;
            stream_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= start_addr;
            rem_q    <= start_len;
            write_q  <= req_write;
            swap_q   <= eff_swap;
            stream_q <= req_stream;
        end else if (last_ack) begin
            addr_q <= addr_q + AW'(blen);
            rem_q  <= rem_q - blen;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        mem_valid = (state_q == ST_ISSUE);
        mem_addr  = addr_q;
        mem_len   = blen;
        mem_write = write_q;
        swap_act  = swap_q && busy;
        adv_valid = last_ack && stream_q;
        adv_len   = blen;
    end
endmodule

// File: rtl/hsd_dma_bridge.sv
module hsd_dma_bridge #(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int DW    = 32,
    parameter int CHUNK = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_load,
    input  logic [AW-1:0] base_data,
    input  logic          cur_load,
    input  logic [AW-1:0] cur_data,
    output logic [AW-1:0] cur_addr,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_write,
    input  logic          req_swap,
    input  logic          req_stream,
    output logic          busy,
    output logic          done,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    output logic          mem_write,
    input  logic          mem_ack,
    input  logic [DW-1:0] wr_data_in,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rd_data_out
);
    logic [AW-1:0] base_q, cur_q;
    logic [AW-1:0] start_addr;
    logic [LW-1:0] start_len;
    logic          eff_swap, swap_act, adv_valid;
    logic [LW-1:0] adv_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_load) base_q <= base_data;
            if (cur_load)       cur_q <= cur_data;
            else if (adv_valid) cur_q <= cur_q + AW'(adv_len);
        end
    end

    assign cur_addr = cur_q;

    hsd_addr_former #(.AW(AW), .LW(LW)) u_form (
        .req_addr   (req_addr),
        .req_len    (req_len),
        .base_q     (base_q),
        .cur_q      (cur_q),
        .swap       (req_swap),
        .stream     (req_stream),
        .start_addr (start_addr),
        .start_len  (start_len),
        .eff_swap   (eff_swap)
    );

    hsd_seq #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .start_addr (start_addr),
        .start_len  (start_len),
        .req_write  (req_write),
        .eff_swap   (eff_swap),
        .req_stream (req_stream),
        .mem_ready  (mem_ready),
        .mem_ack    (mem_ack),
        .busy       (busy),
        .done       (done),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_write  (mem_write),
        .swap_act   (swap_act),
        .adv_valid  (adv_valid),
        .adv_len    (adv_len)
    );

    hsd_lane_swap #(.DW(DW)) u_wswap (
        .en   (swap_act),
        .din  (wr_data_in),
        .dout (mem_wdata)
    );

    hsd_lane_swap #(.DW(DW)) u_rswap (
        .en   (swap_act),
        .din  (mem_rdata),
        .dout (rd_data_out)
    );
endmodule

// File: rtl/hsd_checker.sv
module hsd_checker #(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int CHUNK = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [LW-1:0] mem_len,
    input logic          mem_write,
    input logic          swap_act
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_len) && $stable(mem_write)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid && !done); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy |=> busy); // R8
    AST_EVEN_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && swap_act |-> !mem_addr[0] && !mem_len[0]); // R3
    AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && swap_act && mem_write |-> mem_len <= LW'(CHUNK)); // R5
    AST_NO_EMPTY_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_len != '0); // R10
endmodule

bind hsd_dma_bridge hsd_checker #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .mem_write (mem_write),
    .swap_act  (swap_act)
);

// File: tb/sim_hsd_dma_bridge.sv
module sim_hsd_dma_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_load = 1'b0, cur_load = 1'b0;
    logic [31:0] base_data = '0, cur_data = '0, cur_addr;
    logic        req_valid = 1'b0, req_write = 1'b0, req_swap = 1'b0, req_stream = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        busy, done, mem_valid, mem_write;
    logic        mem_ready = 1'b0, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [15:0] mem_len;
    logic [31:0] wr_data_in = '0, mem_wdata, mem_rdata = '0, rd_data_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] base_m = '0;
    logic [31:0] cur_m = '0;

    always #4 clk = ~clk;

    hsd_dma_bridge u0 (.*);

    // {write, swap, stream, addr[31:0], len[15:0]}
    localparam logic [50:0] VEC [8] = '{
        {1'b1, 1'b1, 1'b0, 32'h0000_0100, 16'd200},
        {1'b1, 1'b1, 1'b0, 32'h0000_0101, 16'd129},
        {1'b0, 1'b1, 1'b0, 32'h0000_0203, 16'd151},
        {1'b1, 1'b0, 1'b0, 32'h0000_0305, 16'd131},
        {1'b1, 1'b1, 1'b0, 32'h0000_0400, 16'd1},
        {1'b0, 1'b0, 1'b1, 32'h0000_0777, 16'd20},
        {1'b1, 1'b1, 1'b1, 32'h0000_0555, 16'd101},
        {1'b1, 1'b1, 1'b0, 32'h0000_0600, 16'd64}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] swap16(input logic [31:0] d);
        return {d[23:16], d[31:24], d[7:0], d[15:8]};
    endfunction

    task automatic do_xfer(input logic wr, input logic sw, input logic st,
                           input logic [31:0] a, input logic [15:0] l,
                           input bit poke, input bit dchk);
        logic [31:0] ea;
        logic [15:0] el, rem, blen;
        bit          sw_eff;
        sw_eff = sw && !st;
        ea = st ? cur_m : (a | base_m);
        el = l;
        if (sw_eff) begin
            ea[0] = 1'b0;
            el[0] = 1'b0;
        end
        @(negedge clk);
        chk(busy == 1'b0, "R8 idle before request", 64'(busy), 64'd0);
        req_valid = 1'b1; req_write = wr; req_swap = sw; req_stream = st;
        req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
        rem = el;
        while (rem != 0) begin
            blen = (sw_eff && wr && rem > 16'd64) ? 16'd64 : rem;
            chk(mem_valid == 1'b1, "R11 burst request valid", 64'(mem_valid), 64'd1);
            chk(mem_addr == ea, st ? "R7 stream address" : "R2/R3 burst address", 64'(mem_addr), 64'(ea));
            chk(mem_len == blen, st ? "R7 stream length" : (sw_eff && wr) ? "R5 chunk length" : "R6 single length",
                64'(mem_len), 64'(blen));
            chk(mem_write == wr, "R6 direction", 64'(mem_write), 64'(wr));
            if (dchk) begin
                wr_data_in = 32'h1122_3344;
                mem_rdata  = 32'hA1B2_C3D4;
                #1;
                chk(mem_wdata == (sw_eff ? swap16(32'h1122_3344) : 32'h1122_3344), "R4 write lanes",
                    64'(mem_wdata), 64'(sw_eff ? swap16(32'h1122_3344) : 32'h1122_3344));
                chk(rd_data_out == (sw_eff ? swap16(32'hA1B2_C3D4) : 32'hA1B2_C3D4), "R4 read lanes",
                    64'(rd_data_out), 64'(sw_eff ? swap16(32'hA1B2_C3D4) : 32'hA1B2_C3D4));
            end
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
            chk(mem_valid == 1'b0, "R11 valid low while waiting", 64'(mem_valid), 64'd0);
            mem_ack = 1'b1;
            if (poke) begin
                req_valid = 1'b1; req_stream = 1'b1; req_len = 16'd9; req_addr = 32'hDEAD_0001;
            end
            @(negedge clk);
            mem_ack = 1'b0;
            req_valid = 1'b0;
            rem = rem - blen;
            ea = ea + 32'(blen);
        end
        if (st) cur_m = cur_m + 32'(el);
        chk(done == 1'b1, (el == 0) ? "R10 immediate done" : "R9 done after last ack", 64'(done), 64'd1);
        chk(mem_valid == 1'b0, "R10 no request at done", 64'(mem_valid), 64'd0);
        chk(cur_addr == cur_m, "R7 current address update", 64'(cur_addr), 64'(cur_m));
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
        chk(busy == 1'b0, "R9 idle after done", 64'(busy), 64'd0);
        chk(cur_addr == cur_m, "R8 ignored request leaves cur", 64'(cur_addr), 64'(cur_m));
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(mem_valid == 1'b0, "R1 mem_valid", 64'(mem_valid), 64'd0);
        chk(cur_addr == 32'd0, "R1 cur_addr", 64'(cur_addr), 64'd0);
        // R4 passthrough while idle
        wr_data_in = 32'h1122_3344; mem_rdata = 32'h5566_7788;
        #1;
        chk(mem_wdata == 32'h1122_3344, "R4 idle write passthrough", 64'(mem_wdata), 64'h1122_3344);
        chk(rd_data_out == 32'h5566_7788, "R4 idle read passthrough", 64'(rd_data_out), 64'h5566_7788);
        // R12 register loads
        @(negedge clk);
        base_load = 1'b1; base_data = 32'h8000_0000;
        cur_load = 1'b1;  cur_data = 32'h0000_1000;
        @(negedge clk);
        base_load = 1'b0; cur_load = 1'b0;
        base_m = 32'h8000_0000; cur_m = 32'h0000_1000;
        chk(cur_addr == 32'h1000, "R12 cur load", 64'(cur_addr), 64'h1000);

        for (int i = 0; i < 8; i++) begin
            do_xfer(VEC[i][50], VEC[i][49], VEC[i][48], VEC[i][47:16], VEC[i][15:0], 1'b0, 1'b0);
        end

        // R10 zero length, unswapped
        do_xfer(1'b0, 1'b0, 1'b0, 32'h20, 16'd0, 1'b0, 1'b0);
        // R4 data lanes: swapped write, swapped read, unswapped write
        do_xfer(1'b1, 1'b1, 1'b0, 32'h40, 16'd8, 1'b0, 1'b1);
        do_xfer(1'b0, 1'b1, 1'b0, 32'h40, 16'd8, 1'b0, 1'b1);
        do_xfer(1'b1, 1'b0, 1'b0, 32'h40, 16'd8, 1'b0, 1'b1);
        // R8 requests while busy are ignored
        do_xfer(1'b1, 1'b1, 1'b0, 32'h80, 16'd130, 1'b1, 1'b0);
        // R2/R12 new base value
        @(negedge clk);
        base_load = 1'b1; base_data = 32'h0040_0000;
        @(negedge clk);
        base_load = 1'b0; base_m = 32'h0040_0000;
        do_xfer(1'b0, 1'b1, 1'b0, 32'h13, 16'd4, 1'b0, 1'b0);
        // R7 stream after current-address reload
        @(negedge clk);
        cur_load = 1'b1; cur_data = 32'h0000_2001;
        @(negedge clk);
        cur_load = 1'b0; cur_m = 32'h0000_2001;
        do_xfer(1'b1, 1'b0, 1'b1, 32'h0, 16'd7, 1'b0, 1'b1);

        finish_run();
    end
endmodule